// File: doc/BRIEF.md
# EISA Slave Bus Front End

This block sits between a 32-bit EISA-style host bus and the internals of a peripheral. On the I/O side it holds the register address and the address-enable qualifier around the active-low address start strobe. It compares the held address against a base value that sets a 16-byte register window, and it turns falling edges of the bus command strobe into one-cycle read and write pulses for the register file behind it. The command timing comes from outside the block. The block never asks the bus for wait states on I/O cycles.

On the DMA side the block acts as a burst slave and moves one 32-bit doubleword per bus clock. Word alignment is assumed, so no byte lanes are decoded. Each beat is gated by the sampled ready line. While that line is low, the current word stays where it is and the beat counter does not move. The internal FIFO is seen as a valid/ready port. In the bus-to-peripheral direction the block pushes words into it. In the peripheral-to-bus direction it pops words from it. No word is lost across a stall.

All inputs are sampled on the bus clock. A synchronous active-high reset returns the block to idle.

Top module: `eisa_slave_front`

## Requirements
- R1: While `rst` is high, at the next clock edge: `aen_latched` reads 1 when `start_n` is high; `io_sel`, `io_rd_stb`, `io_wr_stb`, `push_valid` and `bus_data_valid` are 0; `dma_count` is 0.
- R2: The held address is the value of `addr_in` on the last clock edge at which `start_n` was low. Changes to `addr_in` while `start_n` stays high do not affect `io_sel` or `io_offset`.
- R3: While `start_n` is low, `aen_latched` equals `aen_in` in the same cycle. While `start_n` is high, it keeps the value that `aen_in` had on the last edge at which `start_n` was low.
- R4: `io_sel` is 1 exactly when `aen_latched` is 0 and held address bits [15:4] equal `base_addr`.
- R5: `io_offset` equals held address bits [3:2]. It selects one of four doubleword registers in the window.
- R6: A clock edge that samples `cmd_n` low, after the previous edge sampled it high, with `io_sel` at 1, drives a pulse one cycle long after that edge. The pulse is on `io_wr_stb` when `wr_not_rd` is 1 and on `io_rd_stb` when it is 0. The two pulses are never high together.
- R7: No strobe is produced while `io_sel` is 0. This covers both an address-enable of 1 and an address outside the window.
- R8: With `dma_burst`=1 and `dma_wr`=1, an edge with `exrdy`=1 and a free output slot (`push_valid`=0 or `push_ready`=1) takes `bus_data_in`. That word appears on `push_data`, with `push_valid`=1, after the edge. It is held until an edge with `push_ready`=1.
- R9: With `dma_burst`=1 and `dma_wr`=0, `pop_ready` equals `exrdy`. Each edge with `pop_valid`=1 and `pop_ready`=1 takes `pop_data`. That word is driven on `bus_data_out`, with `bus_data_valid`=1, after the edge.
- R10: On an edge that samples `exrdy` low during a burst: no word is taken or popped, `dma_count` is unchanged, and a word already on `bus_data_out` or `push_data` is held.
- R11: `dma_count` rises by one for each word taken in either direction. It restarts from zero on the first edge at which `dma_burst` is sampled high after being low.
- R12: With `exrdy` and the internal port ready on every cycle, a burst of N cycles moves N words. This is one doubleword per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Address start strobe, active low |
| addr_in | input | 14 | Bus address bits [15:2] |
| aen_in | input | 1 | Address-enable qualifier, access allowed when low |
| base_addr | input | 12 | Window base, compared to address bits [15:4] |
| cmd_n | input | 1 | Bus command strobe, active low |
| wr_not_rd | input | 1 | 1 for a write, 0 for a read |
| io_sel | output | 1 | Register window hit |
| io_offset | output | 2 | Register index inside the window |
| aen_latched | output | 1 | Transparent-low latched address enable |
| io_rd_stb | output | 1 | One-cycle register read pulse |
| io_wr_stb | output | 1 | One-cycle register write pulse |
| dma_burst | input | 1 | DMA burst in progress |
| dma_wr | input | 1 | 1: bus to peripheral, 0: peripheral to bus |
| exrdy | input | 1 | Bus ready line sampled on each beat |
| bus_data_in | input | 32 | Burst data from the bus |
| bus_data_out | output | 32 | Burst data to the bus |
| bus_data_valid | output | 1 | `bus_data_out` holds a word for the bus |
| push_valid | output | 1 | Word offered to the internal FIFO |
| push_data | output | 32 | Word offered to the internal FIFO |
| push_ready | input | 1 | Internal FIFO accepts the pushed word |
| pop_valid | input | 1 | Internal FIFO has a word |
| pop_data | input | 32 | Word from the internal FIFO |
| pop_ready | output | 1 | Block takes the FIFO word this cycle |
| dma_count | output | 16 | Words moved in the current burst |

## Verification
Some properties are checked on every cycle:
- the address enable and window select stay frozen while the start strobe is high and the base is steady;
- strobes last one cycle and never overlap;
- held words stay stable across a low ready line or a blocked internal port;
- the beat counter never advances by more than one.

Other behaviour is shown only by the bench scenarios:
- the exact sample point of the address;
- the transparent phase of the enable;
- which strobe fires for a hit, a disabled access and a miss;
- the order and completeness of words in both DMA directions under ready stalls, an empty FIFO and a full push slot;
- the counter restart at a new burst.

// File: rtl/eisa_fe_pkg.sv
package eisa_fe_pkg;

    // Direction of a DMA burst as seen from the peripheral
    typedef enum logic {
        DIR_TO_BUS   = 1'b0,
        DIR_FROM_BUS = 1'b1
    } dma_dir_e;

    // Kind of register access derived from the command strobe
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } io_acc_e;

endpackage

// File: rtl/eisa_fe_addr_latch.sv
module eisa_fe_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic [ADDR_W-1:2] addr_in,
    input  logic              aen_in,
    output logic [ADDR_W-1:2] addr_hold,
    output logic              aen_eff
);

    typedef struct packed {
        logic [ADDR_W-1:2] addr;
        logic              aen;
    } cap_t;

    cap_t cap_d, cap_q;

    // While the start strobe is low both captures follow the bus; the
    // value present on the last low edge is what remains after it rises.
    always_comb begin
        cap_d = cap_q;
        if (!start_n) begin
            cap_d.addr = addr_in;
            cap_d.aen  = aen_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '{addr: '0, aen: 1'b1};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_hold = cap_q.addr;
    // Transparent while the strobe is low, held once it is high
    assign aen_eff   = start_n ? cap_q.aen : aen_in;

endmodule

// File: rtl/eisa_fe_io_decode.sv
module eisa_fe_io_decode
    import eisa_fe_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:2]        addr_hold,
    input  logic                     aen_eff,
    input  logic [ADDR_W-1:WIN_BITS] base_addr,
    input  logic                     cmd_n,
    input  logic                     wr_not_rd,
    output logic                     io_sel,
    output logic [WIN_BITS-1:2]      io_offset,
    output logic                     io_rd_stb,
    output logic                     io_wr_stb
);

    localparam int BASE_W = ADDR_W - WIN_BITS;

    typedef struct packed {
        logic    cmd_prev;
        io_acc_e acc;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [BASE_W-1:0] bit_eq;
    logic              cmd_fall;

    // Per-bit window compare
    for (genvar b = 0; b < BASE_W; b++) begin : g_cmp
        assign bit_eq[b] = (addr_hold[WIN_BITS + b] == base_addr[WIN_BITS + b]);
    end

    assign io_sel    = (&bit_eq) && !aen_eff;
    assign io_offset = addr_hold[WIN_BITS-1:2];
    assign cmd_fall  = dec_q.cmd_prev && !cmd_n;

    always_comb begin
        dec_d          = dec_q;
        dec_d.cmd_prev = cmd_n;
        dec_d.acc      = ACC_NONE;
        if (cmd_fall && io_sel) begin
            dec_d.acc = wr_not_rd ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{cmd_prev: 1'b1, acc: ACC_NONE};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign io_rd_stb = (dec_q.acc == ACC_READ);
    assign io_wr_stb = (dec_q.acc == ACC_WRITE);

endmodule

// File: rtl/eisa_fe_dma_path.sv
module eisa_fe_dma_path
    import eisa_fe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_burst,
    input  logic              dma_wr,
    input  logic              exrdy,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_valid,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    input  logic              push_ready,
    input  logic              pop_valid,
    input  logic [DATA_W-1:0] pop_data,
    output logic              pop_ready,
    output logic [CNT_W-1:0]  dma_count
);

    typedef struct packed {
        logic              burst_prev;
        logic              push_valid;
        logic [DATA_W-1:0] push_data;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic [CNT_W-1:0]  count;
    } beat_t;

    beat_t    bt_d, bt_q;
    dma_dir_e dir;
    logic     burst_rise;
    logic     slot_free;
    logic     wr_take;
    logic     rd_take;
    logic     beat;

    assign dir        = dma_dir_e'(dma_wr);
    assign burst_rise = dma_burst && !bt_q.burst_prev;
    assign slot_free  = !bt_q.push_valid || push_ready;
    assign pop_ready  = dma_burst && (dir == DIR_TO_BUS) && exrdy;
    assign wr_take    = dma_burst && (dir == DIR_FROM_BUS) && exrdy && slot_free;
    assign rd_take    = pop_ready && pop_valid;
    assign beat       = wr_take || rd_take;

    always_comb begin
        logic [CNT_W-1:0] cnt_base;
        bt_d            = bt_q;
        bt_d.burst_prev = dma_burst;

        // Bus to peripheral: one-word slot toward the FIFO
        if (bt_q.push_valid && push_ready) begin
            bt_d.push_valid = 1'b0;
        end
        if (wr_take) begin
            bt_d.push_valid = 1'b1;
            bt_d.push_data  = bus_data_in;
        end

        // Peripheral to bus: word held on the bus until ready samples high
        if (!dma_burst) begin
            bt_d.out_valid = 1'b0;
        end else if (exrdy) begin
            bt_d.out_valid = rd_take;
        end
        if (rd_take) begin
            bt_d.out_data = pop_data;
        end

        cnt_base   = burst_rise ? '0 : bt_q.count;
        bt_d.count = cnt_base + CNT_W'(beat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bt_q <= '{burst_prev: 1'b0, push_valid: 1'b0, push_data: '0,
                      out_valid: 1'b0, out_data: '0, count: '0};
        end else begin
            bt_q <= bt_d;
        end
    end

    assign push_valid     = bt_q.push_valid;
    assign push_data      = bt_q.push_data;
    assign bus_data_valid = bt_q.out_valid;
    assign bus_data_out   = bt_q.out_data;
    assign dma_count      = bt_q.count;

endmodule

// File: rtl/eisa_slave_front.sv
module eisa_slave_front #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 4,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_n,
    input  logic [ADDR_W-1:2]        addr_in,
    input  logic                     aen_in,
    input  logic [ADDR_W-1:WIN_BITS] base_addr,
    input  logic                     cmd_n,
    input  logic                     wr_not_rd,
    output logic                     io_sel,
    output logic [WIN_BITS-1:2]      io_offset,
    output logic                     aen_latched,
    output logic                     io_rd_stb,
    output logic                     io_wr_stb,
    input  logic                     dma_burst,
    input  logic                     dma_wr,
    input  logic                     exrdy,
    input  logic [DATA_W-1:0]        bus_data_in,
    output logic [DATA_W-1:0]        bus_data_out,
    output logic                     bus_data_valid,
    output logic                     push_valid,
    output logic [DATA_W-1:0]        push_data,
    input  logic                     push_ready,
    input  logic                     pop_valid,
    input  logic [DATA_W-1:0]        pop_data,
    output logic                     pop_ready,
    output logic [CNT_W-1:0]         dma_count
);

    logic [ADDR_W-1:2] addr_hold;
    logic              aen_eff;

    eisa_fe_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .start_n   (start_n),
        .addr_in   (addr_in),
        .aen_in    (aen_in),
        .addr_hold (addr_hold),
        .aen_eff   (aen_eff)
    );

    eisa_fe_io_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .addr_hold (addr_hold),
        .aen_eff   (aen_eff),
        .base_addr (base_addr),
        .cmd_n     (cmd_n),
        .wr_not_rd (wr_not_rd),
        .io_sel    (io_sel),
        .io_offset (io_offset),
        .io_rd_stb (io_rd_stb),
        .io_wr_stb (io_wr_stb)
    );

    eisa_fe_dma_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dma (
        .clk            (clk),
        .rst            (rst),
        .dma_burst      (dma_burst),
        .dma_wr         (dma_wr),
        .exrdy          (exrdy),
        .bus_data_in    (bus_data_in),
        .bus_data_out   (bus_data_out),
        .bus_data_valid (bus_data_valid),
        .push_valid     (push_valid),
        .push_data      (push_data),
        .push_ready     (push_ready),
        .pop_valid      (pop_valid),
        .pop_data       (pop_data),
        .pop_ready      (pop_ready),
        .dma_count      (dma_count)
    );

    assign aen_latched = aen_eff;

endmodule

// File: rtl/eisa_slave_front_chk.sv
module eisa_slave_front_chk #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 4,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start_n,
    input logic [ADDR_W-1:WIN_BITS] base_addr,
    input logic                     io_sel,
    input logic                     aen_latched,
    input logic                     io_rd_stb,
    input logic                     io_wr_stb,
    input logic                     dma_burst,
    input logic                     exrdy,
    input logic [DATA_W-1:0]        bus_data_out,
    input logic                     bus_data_valid,
    input logic                     push_valid,
    input logic [DATA_W-1:0]        push_data,
    input logic                     push_ready,
    input logic [CNT_W-1:0]         dma_count
);

    // High once the previous cycle was already out of reset
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3: enable frozen while the start strobe stays high
    assert_aen_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && start_n && $past(start_n)) |-> $stable(aen_latched));

    // R2 / R4: window select frozen while strobe high and base steady
    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && start_n && $past(start_n) && $stable(base_addr)) |-> $stable(io_sel));

    // R6: strobes are single-cycle and never overlap
    assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        io_rd_stb |=> !io_rd_stb);
    assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        io_wr_stb |=> !io_wr_stb);
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(io_rd_stb && io_wr_stb));

    // R8: pushed word held until the FIFO takes it
    assert_push_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

    // R10: bus word held across a low ready line
    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_data_valid && !exrdy && dma_burst) |=> (bus_data_valid && $stable(bus_data_out)));

    // R10: count frozen on a stalled beat inside a running burst
    assert_stall_count_R10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && dma_burst && $past(dma_burst) && !exrdy) |=> $stable(dma_count));

    // R11: count steps by at most one inside a running burst
    assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
        (past_ok && dma_burst && $past(dma_burst)) |=> ((dma_count - $past(dma_count)) <= CNT_W'(1)));

endmodule

bind eisa_slave_front eisa_slave_front_chk #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_eisa_slave_front.sv
module test_eisa_slave_front;

    localparam int ADDR_W   = 16;
    localparam int WIN_BITS = 4;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam logic [11:0] BASE = 12'h2A5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst;
    logic                     start_n;
    logic [ADDR_W-1:2]        addr_in;
    logic                     aen_in;
    logic [ADDR_W-1:WIN_BITS] base_addr;
    logic                     cmd_n;
    logic                     wr_not_rd;
    logic                     io_sel;
    logic [WIN_BITS-1:2]      io_offset;
    logic                     aen_latched;
    logic                     io_rd_stb;
    logic                     io_wr_stb;
    logic                     dma_burst;
    logic                     dma_wr;
    logic                     exrdy;
    logic [DATA_W-1:0]        bus_data_in;
    logic [DATA_W-1:0]        bus_data_out;
    logic                     bus_data_valid;
    logic                     push_valid;
    logic [DATA_W-1:0]        push_data;
    logic                     push_ready;
    logic                     pop_valid;
    logic [DATA_W-1:0]        pop_data;
    logic                     pop_ready;
    logic [CNT_W-1:0]         dma_count;

    eisa_slave_front i_eisa_slave_front (.*);

    int checks   = 0;
    int failures = 0;
    logic [DATA_W-1:0] exp_push_q[$];
    logic [DATA_W-1:0] exp_bus_q[$];

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] word_of(input int i);
        return 32'hC0DE0000 + DATA_W'(i) * 32'h00010003;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Scoreboard monitor: sampled 2 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && push_valid && push_ready) begin
                if (exp_push_q.size() == 0) begin
                    check(1'b0, "R8 unexpected push", push_data, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_push_q.pop_front();
                    check(push_data == e, "R8 push word", push_data, e);
                end
            end
            if (!rst && bus_data_valid && exrdy) begin
                if (exp_bus_q.size() == 0) begin
                    check(1'b0, "R9 unexpected bus word", bus_data_out, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_bus_q.pop_front();
                    check(bus_data_out == e, "R9 bus word", bus_data_out, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic io_cycle(input logic [15:0] a, input logic aen,
                            input logic wr, input logic exp_sel);
        string tag;
        tag = exp_sel ? "R6" : "R7";
        @(negedge clk);
        start_n = 1'b0; addr_in = a[15:2]; aen_in = aen;
        @(negedge clk);
        check(aen_latched == aen, "R3 transparent", aen_latched, aen);
        aen_in = ~aen;
        @(negedge clk);
        check(aen_latched == ~aen, "R3 follows input", aen_latched, ~aen);
        aen_in = aen;
        @(negedge clk);
        start_n = 1'b1;
        @(negedge clk);
        addr_in = ~a[15:2]; aen_in = ~aen;
        @(negedge clk);
        check(aen_latched == aen, "R3 held", aen_latched, aen);
        check(io_sel == exp_sel, "R2 R4 select", io_sel, exp_sel);
        check(io_offset == a[3:2], "R2 R5 offset", io_offset, a[3:2]);
        cmd_n = 1'b0; wr_not_rd = wr;
        @(negedge clk);
        check(io_rd_stb == (exp_sel && !wr), {tag, " read strobe"}, io_rd_stb, exp_sel && !wr);
        check(io_wr_stb == (exp_sel && wr), {tag, " write strobe"}, io_wr_stb, exp_sel && wr);
        cmd_n = 1'b1;
        @(negedge clk);
        check(!io_rd_stb && !io_wr_stb, "R6 single pulse", {io_rd_stb, io_wr_stb}, 0);
    endtask

    task automatic dma_write_burst(input int base_i);
        int  k = 0;
        int  exp_count = 0;
        bit  full = 1'b0;
        for (int cyc = 0; cyc < 12; cyc++) begin
            @(negedge clk);
            if (cyc > 0)
                check(dma_count == CNT_W'(exp_count), "R10 R11 write count", dma_count, exp_count);
            dma_burst   = 1'b1;
            dma_wr      = 1'b1;
            exrdy       = !(cyc == 2 || cyc == 3);
            push_ready  = !(cyc == 5 || cyc == 6);
            bus_data_in = word_of(base_i + k);
            if (exrdy && (!full || push_ready)) begin
                exp_push_q.push_back(bus_data_in);
                k++; exp_count++; full = 1'b1;
            end else if (push_ready) begin
                full = 1'b0;
            end
        end
        @(negedge clk);
        check(dma_count == CNT_W'(exp_count), "R11 write total", dma_count, exp_count);
        dma_burst = 1'b0; push_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(exp_push_q.size() == 0, "R8 all words pushed", exp_push_q.size(), 0);
        check(!push_valid, "R8 slot drained", push_valid, 0);
    endtask

    task automatic dma_read_burst(input int base_i, input bit stalls, input int n);
        int k = 0;
        int exp_count = 0;
        for (int cyc = 0; cyc < n; cyc++) begin
            @(negedge clk);
            if (cyc > 0)
                check(dma_count == CNT_W'(exp_count), "R10 R11 read count", dma_count, exp_count);
            dma_burst = 1'b1;
            dma_wr    = 1'b0;
            exrdy     = stalls ? !(cyc == 3 || cyc == 4) : 1'b1;
            pop_valid = stalls ? (cyc != 7) : 1'b1;
            pop_data  = word_of(base_i + k);
            #1;
            check(pop_ready == exrdy, "R9 R10 pop ready", pop_ready, exrdy);
            if (exrdy && pop_valid) begin
                exp_bus_q.push_back(pop_data);
                k++; exp_count++;
            end
        end
        @(negedge clk);
        check(dma_count == CNT_W'(exp_count), "R11 read total", dma_count, exp_count);
        if (!stalls)
            check(dma_count == CNT_W'(n), "R12 one word per clock", dma_count, n);
        dma_burst = 1'b0; exrdy = 1'b1; pop_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(exp_bus_q.size() == 0, "R9 all words on bus", exp_bus_q.size(), 0);
        check(!bus_data_valid, "R9 bus idle after burst", bus_data_valid, 0);
    endtask

    initial begin
        rst = 1'b1; start_n = 1'b1; addr_in = '0; aen_in = 1'b1;
        base_addr = BASE; cmd_n = 1'b1; wr_not_rd = 1'b0;
        dma_burst = 1'b0; dma_wr = 1'b0; exrdy = 1'b1; bus_data_in = '0;
        push_ready = 1'b1; pop_valid = 1'b0; pop_data = '0;
        repeat (3) @(negedge clk);
        check(aen_latched == 1'b1, "R1 enable idle", aen_latched, 1);
        check(!io_sel, "R1 select clear", io_sel, 0);
        check(!io_rd_stb && !io_wr_stb, "R1 strobes clear", {io_rd_stb, io_wr_stb}, 0);
        check(!push_valid, "R1 push clear", push_valid, 0);
        check(!bus_data_valid, "R1 bus clear", bus_data_valid, 0);
        check(dma_count == '0, "R1 count clear", dma_count, 0);
        rst = 1'b0;

        io_cycle(16'h2A58, 1'b0, 1'b0, 1'b1);  // hit, read, index 2
        io_cycle(16'h2A5C, 1'b0, 1'b1, 1'b1);  // hit, write, index 3
        io_cycle(16'h2A54, 1'b1, 1'b1, 1'b0);  // enable high: no access
        io_cycle(16'h3A50, 1'b0, 1'b0, 1'b0);  // outside window

        dma_write_burst(0);
        dma_read_burst(100, 1'b1, 10);
        dma_read_burst(200, 1'b0, 4);

        repeat (2) @(negedge clk);
        summary();
    end

endmodule